// File: doc/BRIEF.md
# Newton-Iteration Integer Square Root with Request/Finish Handshake

This block returns the floor of the square root of an unsigned word. The producer places a value on the data input and raises the request line. The block answers by raising its finish line once the result output holds the root. There is no acknowledge line and no valid/ready bus. The producer keeps the data stable until finish rises. The next computation begins only when the request line goes low and then rises again.

A local clock samples the request line through a synchronizer, and a rising edge is found by comparing two registered samples. The root comes from Newton's iteration, where the next estimate is (x + a/x)/2. The starting guess is a power of two that is never below the true root. Each quotient comes from a sequential restoring divider. The loop ends as soon as a new estimate is not smaller than the current one, and the current estimate is then the floor root. Inputs 0 and 1 skip the divider completely.

Top module: `nsqrt_core`

## Requirements
- R1: While reset is high, and in the cycle after it, `fin_out` is 0 and `root_out` is 0.
- R2: When `fin_out` is high, `root_out` = r satisfies r*r <= a < (r+1)*(r+1), where a is the value of `data_in` captured at the accepted request edge.
- R3: With the default width of 32, the input 10454520 yields 3233.
- R4: The input 0 yields 0 and the input 1 yields 1. Neither uses a division.
- R5: Accepting a rising request edge while `fin_out` is high drives `fin_out` to 0 on the next clock edge. It stays at 0 until the new result is ready.
- R6: A rising request edge that arrives while a computation is running is ignored. The result that follows belongs to the earlier request, and `fin_out` stays high afterwards with no new run.
- R7: Only a 0-to-1 change of `req_in` starts work. Holding `req_in` high after completion leaves `fin_out` high and `root_out` unchanged.
- R8: While `fin_out` stays high, `root_out` does not change.
- R9: Perfect squares give their exact root. The all-ones input of width 32 gives 65535.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| req_in | input | 1 | Request line; a rising edge starts a computation |
| data_in | input | W | Unsigned operand, held stable by the producer |
| fin_out | output | 1 | Finish line; rises when the result is valid |
| root_out | output | W | Floor square root, held until the next completion |

## Verification
Some properties are checked on every cycle while the block runs:
- The floor-root bound against the captured operand whenever finish is high.
- The reset state.
- That finish drops immediately after an accepted edge.
- That finish stays low while the loop or divider is busy.
- That the result does not move while finish is high.

Other behaviours show up only in the bench's directed scenarios:
- That a request edge during a run is lost rather than queued.
- That a steadily held request does not start a second run.
- The specific values for the known operand, the small inputs, perfect squares and the all-ones word.

// File: rtl/nsqrt_pkg.sv
package nsqrt_pkg;

  localparam int NSQ_DEFAULT_W = 32;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LAUNCH,
    ST_DIVIDE,
    ST_STEP,
    ST_FINISH,
    ST_HOLD
  } nsq_state_t;

endpackage

// File: rtl/nsqrt_reqsync.sv
module nsqrt_reqsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic req_async,
  output logic req_rise
);

  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_sync
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= 1'b0;
          else     chain_q[0] <= req_async;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (rst) chain_q[i] <= 1'b0;
          else     chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= chain_q[STAGES-1];
  end

  assign req_rise = chain_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/nsqrt_divider.sv
module nsqrt_divider #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         done,
  output logic [W-1:0] quotient
);

  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  rem_q;
  logic [W-1:0]  quo_q;
  logic [CW-1:0] cnt_q;
  logic          run_q;
  logic [W:0]    trial;
  logic [W:0]    diff;
  logic          fits;

  always_comb begin
    trial = {rem_q, quo_q[W-1]};
    diff  = trial - {1'b0, divisor};
    fits  = (trial >= {1'b0, divisor});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q <= '0;
      quo_q <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        rem_q <= '0;
        quo_q <= dividend;
        cnt_q <= CW'(W);
        run_q <= 1'b1;
      end else if (run_q) begin
        rem_q <= fits ? diff[W-1:0] : trial[W-1:0];
        quo_q <= {quo_q[W-2:0], fits};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          run_q <= 1'b0;
          done  <= 1'b1;
        end
      end
    end
  end

  assign quotient = quo_q;

endmodule

// File: rtl/nsqrt_ctrl.sv
module nsqrt_ctrl
  import nsqrt_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         req_rise,
  input  logic [W-1:0] data_in,
  input  logic         div_done,
  input  logic [W-1:0] div_quo,
  output logic         div_start,
  output logic [W-1:0] div_num,
  output logic [W-1:0] div_den,
  output logic         accept,
  output logic         busy,
  output logic [W-1:0] op_val,
  output logic         fin_out,
  output logic [W-1:0] root_out
);

  nsq_state_t   state_q;
  logic [W-1:0] op_q;
  logic [W-1:0] est_q;
  logic [W:0]   sum;
  logic [W-1:0] next_est;
  logic [W-1:0] seed;

  function automatic logic [W-1:0] seed_of(input logic [W-1:0] a);
    int top;
    top = 0;
    for (int i = 0; i < W; i++) begin
      if (a[i]) top = i;
    end
    return W'(1) << ((top + 2) / 2);
  endfunction

  always_comb begin
    seed     = seed_of(data_in);
    sum      = {1'b0, est_q} + {1'b0, div_quo};
    next_est = sum[W:1];
  end

  assign accept    = req_rise && (state_q == ST_IDLE || state_q == ST_HOLD);
  assign busy      = (state_q != ST_IDLE) && (state_q != ST_HOLD);
  assign div_start = (state_q == ST_LAUNCH);
  assign div_num   = op_q;
  assign div_den   = est_q;
  assign op_val    = op_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      op_q     <= '0;
      est_q    <= '0;
      fin_out  <= 1'b0;
      root_out <= '0;
    end else begin
      case (state_q)
        ST_IDLE, ST_HOLD: begin
          if (accept) begin
            fin_out <= 1'b0;
            op_q    <= data_in;
            if (data_in < W'(2)) begin
              est_q   <= data_in;
              state_q <= ST_FINISH;
            end else begin
              est_q   <= seed;
              state_q <= ST_LAUNCH;
            end
          end
        end
        ST_LAUNCH: state_q <= ST_DIVIDE;
        ST_DIVIDE: if (div_done) state_q <= ST_STEP;
        ST_STEP: begin
          if (next_est < est_q) begin
            est_q   <= next_est;
            state_q <= ST_LAUNCH;
          end else begin
            state_q <= ST_FINISH;
          end
        end
        ST_FINISH: begin
          root_out <= est_q;
          fin_out  <= 1'b1;
          state_q  <= ST_HOLD;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/nsqrt_core.sv
module nsqrt_core #(
  parameter int W           = nsqrt_pkg::NSQ_DEFAULT_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         req_in,
  input  logic [W-1:0] data_in,
  output logic         fin_out,
  output logic [W-1:0] root_out
);

  logic         req_rise;
  logic         div_start;
  logic         div_done;
  logic [W-1:0] div_quo;
  logic [W-1:0] div_num;
  logic [W-1:0] div_den;
  logic         accept;
  logic         busy;
  logic [W-1:0] op_val;

  nsqrt_reqsync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .req_async (req_in),
    .req_rise  (req_rise)
  );

  nsqrt_divider #(.W(W)) u_div (
    .clk      (clk),
    .rst      (rst),
    .start    (div_start),
    .dividend (div_num),
    .divisor  (div_den),
    .done     (div_done),
    .quotient (div_quo)
  );

  nsqrt_ctrl #(.W(W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .req_rise  (req_rise),
    .data_in   (data_in),
    .div_done  (div_done),
    .div_quo   (div_quo),
    .div_start (div_start),
    .div_num   (div_num),
    .div_den   (div_den),
    .accept    (accept),
    .busy      (busy),
    .op_val    (op_val),
    .fin_out   (fin_out),
    .root_out  (root_out)
  );

endmodule

// File: rtl/nsqrt_checker.sv
module nsqrt_checker #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         fin,
  input logic [W-1:0] root,
  input logic [W-1:0] op,
  input logic         accept,
  input logic         busy
);

  logic [2*W+1:0] sq_lo;
  logic [2*W+1:0] sq_hi;
  logic [2*W+1:0] op_w;

  always_comb begin
    sq_lo = (2*W+2)'(root) * (2*W+2)'(root);
    sq_hi = ((2*W+2)'(root) + 1) * ((2*W+2)'(root) + 1);
    op_w  = (2*W+2)'(op);
  end

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (!fin && root == '0));

  assert_floor_root_R2: assert property (@(posedge clk) disable iff (rst)
    fin |-> (sq_lo <= op_w && sq_hi > op_w));

  assert_small_input_R4: assert property (@(posedge clk) disable iff (rst)
    (fin && op < W'(2)) |-> (root == op));

  assert_fin_drops_R5: assert property (@(posedge clk) disable iff (rst)
    accept |=> !fin);

  assert_quiet_while_busy_R6: assert property (@(posedge clk) disable iff (rst)
    busy |-> !fin);

  assert_result_held_R8: assert property (@(posedge clk) disable iff (rst)
    (fin && $past(fin)) |-> $stable(root));

endmodule

bind nsqrt_core nsqrt_checker #(.W(W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .fin    (fin_out),
  .root   (root_out),
  .op     (op_val),
  .accept (accept),
  .busy   (busy)
);

// File: tb/test_nsqrt_core.sv
`timescale 1ns/1ps
module test_nsqrt_core;

  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         req_in = 1'b0;
  logic [W-1:0] data_in = '0;
  logic         fin_out;
  logic [W-1:0] root_out;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  nsqrt_core #(.W(W)) i_nsqrt_core (
    .clk      (clk),
    .rst      (rst),
    .req_in   (req_in),
    .data_in  (data_in),
    .fin_out  (fin_out),
    .root_out (root_out)
  );

  function automatic longint ref_root(input longint a);
    longint r = 0;
    for (int b = W/2; b >= 0; b--) begin
      longint t = r | (longint'(1) << b);
      if (t * t <= a) r = t;
    end
    return r;
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_fin(input string req);
    int t = 0;
    while (!fin_out && t < 5000) begin
      @(negedge clk);
      t++;
    end
    if (!fin_out) check({req, " finish timeout"}, 0, 1);
  endtask

  task automatic run_one(input string req, input logic [W-1:0] v);
    @(negedge clk);
    req_in  = 1'b0;
    tick(4);
    data_in = v;
    req_in  = 1'b1;
    tick(6);
    wait_fin(req);
    check(req, root_out, ref_root(longint'(v)));
  endtask

  task automatic t_reset;
    tick(3);
    check("R1 fin after reset", fin_out, 0);
    check("R1 root after reset", root_out, 0);
    rst = 1'b0;
    tick(1);
    check("R1 fin after release", fin_out, 0);
  endtask

  task automatic t_known;
    run_one("R3 known value", 32'd10454520);
    check("R3 exact 3233", root_out, 3233);
  endtask

  task automatic t_small;
    run_one("R4 zero", 32'd0);
    check("R4 zero root", root_out, 0);
    run_one("R4 one", 32'd1);
    check("R4 one root", root_out, 1);
    run_one("R2 two", 32'd2);
    run_one("R2 three", 32'd3);
  endtask

  task automatic t_squares;
    run_one("R9 square 4", 32'd4);
    run_one("R9 square 65536", 32'd65536);
    run_one("R9 square 1048576", 32'd1048576);
    run_one("R9 square 4294836225", 32'd4294836225);
    run_one("R9 all ones", 32'hFFFF_FFFF);
    check("R9 all ones root", root_out, 65535);
  endtask

  task automatic t_mixed;
    run_one("R2 sq-1 15", 32'd15);
    run_one("R2 value 99", 32'd99);
    run_one("R2 value 123456789", 32'd123456789);
    run_one("R2 value 2147483647", 32'd2147483647);
    run_one("R2 value 65535", 32'd65535);
  endtask

  task automatic t_fin_drop;
    run_one("R5 setup", 32'd50);
    check("R5 fin high before", fin_out, 1);
    req_in = 1'b0;
    tick(4);
    data_in = 32'd3000000000;
    req_in  = 1'b1;
    tick(4);
    check("R5 fin low after new request", fin_out, 0);
    wait_fin("R5");
    check("R5 new result", root_out, ref_root(64'd3000000000));
  endtask

  task automatic t_busy_ignore;
    req_in = 1'b0;
    tick(4);
    data_in = 32'd4000000000;
    req_in  = 1'b1;
    tick(10);
    check("R6 busy running", fin_out, 0);
    req_in = 1'b0;
    tick(3);
    data_in = 32'd81;
    req_in  = 1'b1;
    tick(2);
    data_in = 32'd4000000000;
    wait_fin("R6");
    check("R6 result of first request", root_out, ref_root(64'd4000000000));
    tick(40);
    check("R6 no second run fin", fin_out, 1);
    check("R6 no second run root", root_out, ref_root(64'd4000000000));
  endtask

  task automatic t_held_high;
    run_one("R7 setup", 32'd777);
    data_in = 32'd9;
    tick(60);
    check("R7 fin stays high", fin_out, 1);
    check("R8 root held", root_out, ref_root(64'd777));
  endtask

  initial begin
    t_reset();
    t_known();
    t_small();
    t_squares();
    t_mixed();
    t_fin_drop();
    t_busy_ignore();
    t_held_high();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule